// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single READ or WRITE command into the column addresses of a DRAM burst, one column per beat. The burst length, 4 or 8, comes from a small mode register loaded by a mode-set strobe. Only sequential ordering is legal. Every burst stays inside an aligned block of columns the size of the burst. The two lowest column bits given with a command are ignored and forced to zero. A length-8 burst therefore starts at offset 0 or at offset 4, and from offset 4 it wraps back to 0 inside its 8-column block.

A memory controller issues a command when `ready` is high. The block then streams the beat columns on `beat_col` with `beat_valid`. `beat_last` marks the final beat. Commands that arrive while a burst is still running are dropped. A mode-set write that carries a reserved code raises `mode_err`, and the previous legal setting stays in force.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `beat_valid` is 0, `ready` is 1, `mode_err` is 0, and the burst length is 4.
- R2: A command accepted at clock edge n gives beat 0 on the outputs right after edge n. Column bits [1:0] of that beat are 0 whatever the command's bits [1:0] were.
- R3: Mode-set field `mode_bits[2:0]` selects the length: 3'b010 = 4 and 3'b011 = 8. Bit `mode_bits[3]` selects the ordering: 0 = sequential, 1 = interleaved. Any other length code, or bit 3 set, is illegal. An illegal write sets `mode_err` to 1 and leaves the length unchanged. A legal write clears `mode_err`.
- R4: A length-4 burst produces offsets 0,1,2,3 in bits [1:0]. Bits above bit 1 equal the command's bits.
- R5: A length-8 burst whose command bit 2 is 0 produces offsets 0..7 in bits [2:0].
- R6: A length-8 burst whose command bit 2 is 1 produces offsets 4,5,6,7,0,1,2,3 in bits [2:0].
- R7: The column bits above the burst block, and `beat_write`, keep the command's values on every beat of the burst.
- R8: `beat_valid` stays high for exactly the burst length and `beat_last` is high only on the final beat. `ready` is low on every beat except the last. A command presented while `ready` is low is ignored and is neither stored nor replayed.
- R9: A burst keeps the length that was in force when its command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode-set strobe |
| mode_bits | input | 4 | Mode-set field: [2:0] length code, [3] ordering |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Starting column address |
| ready | output | 1 | A command can be taken this cycle |
| beat_valid | output | 1 | Beat column is valid |
| beat_write | output | 1 | Direction of the current burst |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| mode_err | output | 1 | Last mode-set write was illegal |

## Verification
Beat k of a command accepted at edge n is on the outputs between edge n+k and edge n+k+1. The bench therefore drives a command on a falling edge and checks each beat at the following falling edges, one per beat. It also checks that `beat_valid` is low one falling edge after the last beat. A mode-set write takes effect at the next edge, so `mode_err` is sampled at the falling edge after the strobe. The new length is confirmed through the next burst. All start columns are swept for both lengths.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam logic [2:0] BL_CODE_4 = 3'b010;
  localparam logic [2:0] BL_CODE_8 = 3'b011;
  localparam int unsigned BEAT_W   = 3;
  typedef enum logic {LEN_4 = 1'b0, LEN_8 = 1'b1} burst_len_e;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr_i,
  input  logic [3:0] mode_bits_i,
  output burst_len_e len_o,
  output logic       err_o
);
  logic       code_ok;
  burst_len_e len_q, len_d;
  logic       err_q, err_d;
  logic       upd_en;

  always_comb begin
    code_ok = !mode_bits_i[3] &&
              ((mode_bits_i[2:0] == BL_CODE_4) || (mode_bits_i[2:0] == BL_CODE_8));
    upd_en  = mode_wr_i;
    len_d   = len_q;
    err_d   = err_q;
    if (upd_en) begin
      err_d = !code_ok;
      if (code_ok)
        len_d = (mode_bits_i[2:0] == BL_CODE_8) ? LEN_8 : LEN_4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LEN_4;
      err_q <= 1'b0;
    end else if (upd_en) begin
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  assign len_o = len_q;
  assign err_o = err_q;

  AST_BAD_CODE_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && !code_ok) |=> (err_o && $stable(len_o))); // R3
endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] col_i,
  input  burst_len_e       len_i,
  output logic             active_o,
  output logic             last_o,
  output logic             write_o,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned HI_W = COL_W - 2;

  logic              active_q, active_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              len8_q, len8_d;
  logic              wr_q, wr_d;
  logic              last;
  logic              step_en;

  always_comb begin
    last     = active_q && (cnt_q == (len8_q ? 3'd7 : 3'd3));
    step_en  = start_i || active_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    hi_d     = hi_q;
    len8_d   = len8_q;
    wr_d     = wr_q;
    if (start_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      hi_d     = col_i[COL_W-1:2];
      len8_d   = (len_i == LEN_8);
      wr_d     = write_i;
    end else if (active_q) begin
      if (last) active_d = 1'b0;
      cnt_d = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      hi_q     <= '0;
      len8_q   <= 1'b0;
      wr_q     <= 1'b0;
    end else if (step_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      hi_q     <= hi_d;
      len8_q   <= len8_d;
      wr_q     <= wr_d;
    end
  end

  generate
    if (COL_W > 3) begin : g_wide
      assign col_o = {hi_q[HI_W-1:1], hi_q[0] ^ (len8_q & cnt_q[2]), cnt_q[1:0]};
    end else begin : g_narrow
      assign col_o = {hi_q[0] ^ (len8_q & cnt_q[2]), cnt_q[1:0]};
    end
  endgenerate

  assign active_o = active_q;
  assign last_o   = last;
  assign write_o  = wr_q;

  AST_OFFSET_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last && !start_i) |=> (col_o[1:0] == $past(col_o[1:0]) + 2'd1)); // R4
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !last && !start_i) |=> $stable(col_o[COL_W-1:3])); // R7
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [3:0]       mode_bits,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  output logic             ready,
  output logic             beat_valid,
  output logic             beat_write,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             mode_err
);
  burst_len_e len;
  logic       active;
  logic       last;
  logic       accept;

  bcs_mode_reg i_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_bits_i(mode_bits),
    .len_o(len), .err_o(mode_err)
  );

  assign ready  = !active || last;
  assign accept = cmd_valid && ready;

  bcs_beat_gen #(.COL_W(COL_W)) i_gen (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .write_i(cmd_write),
    .col_i(cmd_col), .len_i(len), .active_o(active), .last_o(last),
    .write_o(beat_write), .col_o(beat_col)
  );

  assign beat_valid = active;
  assign beat_last  = last;

  AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (beat_valid && beat_col[1:0] == 2'd0)); // R2
  AST_BURST_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_valid && $stable(beat_write))); // R8
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [3:0] mode_bits = '0;
  logic cmd_valid = 1'b0;
  logic cmd_write = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic ready, beat_valid, beat_write, beat_last, mode_err;
  logic [COL_W-1:0] beat_col;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
    .ready(ready), .beat_valid(beat_valid), .beat_write(beat_write),
    .beat_col(beat_col), .beat_last(beat_last), .mode_err(mode_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] bits);
    @(negedge clk);
    mode_wr = 1'b1; mode_bits = bits;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // Runs one burst and checks every beat; intrude pokes a refused command mid-burst.
  task automatic burst(input int col, input bit wr, input int len, input bit intrude);
    int exp;
    bit full;
    @(negedge clk);
    check("R8 ready idle", int'(ready), 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = COL_W'(col);
    @(negedge clk);
    cmd_valid = 1'b0;
    full = 1'b1;
    for (int b = 0; b < len; b++) begin
      if (len == 4) exp = (col & ~3) | b;
      else exp = (col & ~7) | ((((col >> 2) & 1) * 4 + b) % 8);
      if (beat_valid !== 1'b1 || int'(beat_col) != exp || beat_write !== wr ||
          beat_last !== (b == len - 1) || ready !== (b == len - 1)) full = 1'b0;
      if (!full) begin
        check(len == 4 ? "R4 col" : (((col >> 2) & 1) != 0 ? "R6 col" : "R5 col"),
              int'(beat_col), exp);
        check("R7 write", int'(beat_write), int'(wr));
        check("R8 last", int'(beat_last), int'(b == len - 1));
        check("R8 valid", int'(beat_valid), 1);
        check("R8 ready busy", int'(ready), int'(b == len - 1));
        full = 1'b1;
      end
      if (b == 0) check("R2 aligned", int'(beat_col[1:0]), 0);
      if (intrude && b == 2) begin
        cmd_valid = 1'b1; cmd_col = COL_W'(col ^ 12'h3f8); cmd_write = ~wr;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check("R8 ends", int'(beat_valid), 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(beat_valid), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 err", int'(mode_err), 0);
    rst_n = 1'b1;
    burst(13, 1'b0, 4, 1'b0);             // R1 default length 4, R2 low bits ignored
    for (int c = 0; c < (1 << COL_W); c++) burst(c, c[0], 4, 1'b0); // R4
    set_mode(4'b0011);
    check("R3 legal err", int'(mode_err), 0);
    for (int c = 0; c < (1 << COL_W); c++) burst(c, c[1], 8, 1'b0); // R5 R6 R7
    set_mode(4'b1011);                     // interleaved request
    check("R3 err type", int'(mode_err), 1);
    burst(6, 1'b1, 8, 1'b0);
    set_mode(4'b0111);                     // reserved length
    check("R3 err len", int'(mode_err), 1);
    burst(1021, 1'b0, 8, 1'b0);
    burst(300, 1'b1, 8, 1'b1);             // R8 refused intruder
    burst(4, 1'b0, 8, 1'b1);
    set_mode(4'b0010);
    check("R3 clear", int'(mode_err), 0);
    burst(7, 1'b1, 4, 1'b1);
    // R9: length change during a burst does not affect it
    @(negedge clk);
    cmd_valid = 1'b1; cmd_col = COL_W'(12); cmd_write = 1'b0;
    mode_wr = 1'b1; mode_bits = 4'b0011;
    @(negedge clk);
    cmd_valid = 1'b0; mode_wr = 1'b0;
    for (int b = 0; b < 4; b++) begin
      check("R9 col", int'(beat_col), 12 | b);
      check("R9 last", int'(beat_last), int'(b == 3));
      @(negedge clk);
    end
    check("R9 ends", int'(beat_valid), 0);
    burst(12, 1'b0, 8, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule